// File: doc/BRIEF.md
# Single-Address External DMA Engine

This block is one DMA channel that moves data between external memory and a peripheral in a single bus cycle per transfer. The peripheral is never addressed. It is selected by an active-low acknowledge strobe, and in that same cycle the engine drives the memory address on the external bus. The peripheral drives or samples the data bus directly, so the engine never holds any data. The access size is always the external bus width, given by `BYTES`.

Software programs the channel through a small write port. The port reaches a source memory address, a destination memory address, a transfer count and a control word. The direction bit picks which of the two memory addresses is used, and the other one is left untouched. Once enabled, the channel waits for a peripheral request while the bus is granted. It can insert one idle cycle, and then it runs one bus cycle. After that cycle it steps the address and decrements the count. When the count reaches zero the channel disables itself and raises a sticky done flag. An optional end-of-transfer output marks the final bus cycle, together with the idle cycle placed before it.

Top module: `sadma_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bus_cyc`, `bus_idle` and `xfer_end` are 0 and `dack_n` is 1.
- R2: With direction bit (control bit 1) at 0, each bus cycle is a memory read (`bus_we`=0) at the source address register (select 0). The destination address register has no effect.
- R3: With direction bit 1, each bus cycle is a memory write (`bus_we`=1) at the destination address register (select 1). The source address register has no effect.
- R4: Each transfer is exactly one cycle of `bus_cyc`. When the acknowledge enable (control bit 2) is 1, `dack_n` is low in that cycle and in no other.
- R5: With acknowledge enable 0, `dack_n` stays high during transfers.
- R6: The step field (control bits 5:4) sets the address change after each transfer: 01 adds `BYTES`, 10 subtracts `BYTES`, and 00 or 11 leaves the address unchanged.
- R7: The count register (select 2) drops by one per bus cycle. After the final transfer, `busy` falls, `done` rises, and no further bus cycles occur while requests are held.
- R8: With the end enable (control bit 3) at 1, `xfer_end` is high during the final bus cycle and not during earlier ones. With it at 0, `xfer_end` stays low.
- R9: With the idle enable (control bit 6) at 1, one `bus_idle` cycle directly precedes each bus cycle. If end enable is set, `xfer_end` is also high in the idle cycle before the final bus cycle.
- R10: Requests are ignored while the channel is disabled (control bit 0 at 0) or while `bus_gnt` is low.
- R11: `done` stays set until the control register (select 3) is written with the enable bit 1, which clears it. Enabling with a count of zero leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | ADDR_W | Register write data |
| dreq | input | 1 | Transfer request from the peripheral |
| bus_gnt | input | 1 | External bus granted to this channel |
| bus_addr | output | ADDR_W | Memory address during a bus cycle, 0 otherwise |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Memory write (1) or read (0) |
| bus_idle | output | 1 | Idle cycle inserted before a bus cycle |
| dack_n | output | 1 | Active-low acknowledge to the peripheral |
| xfer_end | output | 1 | End-of-transfer marker |
| busy | output | 1 | Channel enabled |
| done | output | 1 | Sticky completion flag |

## Verification
The hardest condition to reach from the ports is an end-of-transfer marker that spans an idle cycle. It needs idle insertion and the end enable set together, with the count at one just as a request is accepted. The stimulus programs a two-transfer run with idle insertion. It holds the request and grant high and records the idle cycle seen directly before each bus cycle. This checks that the marker is absent in the first idle cycle and present in the second. Ignored requests are reached by holding the request high first with the channel disabled and then with the grant low, before releasing the grant.

// File: rtl/sadma_pkg.sv
// Package: shared encodings for the single-address DMA engine.
// Assumes the register select and control bit layout documented in the brief.
package sadma_pkg;

    // Register select codes on the configuration port
    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    // Control word bit positions
    localparam int CB_EN    = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_ACK   = 2;
    localparam int CB_END   = 3;
    localparam int CB_STEP  = 4;   // two bits, 5:4
    localparam int CB_IDLE  = 6;

    // Address step modes
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLD2 = 2'b11
    } step_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_GAP  = 2'd1,
        ST_XFER = 2'd2
    } seq_e;

endpackage

// File: rtl/sadma_regs.sv
// Channel register file: two memory address registers, the transfer counter
// and the control word. Steps the address selected by the direction bit and
// counts down after every completed bus cycle.
// Assumes xfer_done is high for exactly one cycle per bus cycle.
module sadma_regs
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              enable,
    output logic              dir,
    output logic              ack_en,
    output logic              end_en,
    output logic              idle_en,
    output logic              last,
    output logic              done
);

    localparam logic [ADDR_W-1:0] STEP_SZ = ADDR_W'(BYTES);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    step_e             step_q;
    logic              wr_ctrl;

    assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);

    // Next address after one transfer, per step mode
    function automatic logic [ADDR_W-1:0] stepped(input logic [ADDR_W-1:0] a,
                                                  input step_e m);
        case (m)
            STEP_UP:   stepped = a + STEP_SZ;
            STEP_DOWN: stepped = a - STEP_SZ;
            default:   stepped = a;
        endcase
    endfunction

    // Source address: software write wins, otherwise step on reads from memory
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= '0;
        else if (cfg_we && cfg_sel == SEL_SRC)
            src_q <= cfg_wdata;
        else if (xfer_done && !dir)
            src_q <= stepped(src_q, step_q);
    end

    // Destination address: software write wins, otherwise step on writes to memory
    always_ff @(posedge clk) begin
        if (!rst_n)
            dst_q <= '0;
        else if (cfg_we && cfg_sel == SEL_DST)
            dst_q <= cfg_wdata;
        else if (xfer_done && dir)
            dst_q <= stepped(dst_q, step_q);
    end

    // Transfer counter: load from software, decrement per bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cfg_we && cfg_sel == SEL_CNT)
            cnt_q <= cfg_wdata[CNT_W-1:0];
        else if (xfer_done && cnt_q != '0)
            cnt_q <= cnt_q - CNT_ONE;
    end

    // Control fields: written by software, enable cleared on the final transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable  <= 1'b0;
            dir     <= 1'b0;
            ack_en  <= 1'b0;
            end_en  <= 1'b0;
            idle_en <= 1'b0;
            step_q  <= STEP_HOLD;
        end else if (wr_ctrl) begin
            enable  <= cfg_wdata[CB_EN] && (cnt_q != '0);
            dir     <= cfg_wdata[CB_DIR];
            ack_en  <= cfg_wdata[CB_ACK];
            end_en  <= cfg_wdata[CB_END];
            idle_en <= cfg_wdata[CB_IDLE];
            step_q  <= step_e'(cfg_wdata[CB_STEP +: 2]);
        end else if (xfer_done && last) begin
            enable  <= 1'b0;
        end
    end

    // Sticky done flag: set on the final transfer, cleared by a new enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (wr_ctrl && cfg_wdata[CB_EN])
            done <= 1'b0;
        else if (xfer_done && last)
            done <= 1'b1;
    end

    assign last     = (cnt_q == CNT_ONE);
    assign mem_addr = dir ? dst_q : src_q;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_ctrl && cfg_wdata[CB_EN])) |=> done); // R11
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && last && !wr_ctrl) |=> (!enable && done)); // R7
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !cfg_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R7

endmodule

// File: rtl/sadma_seq.sv
// Transfer sequencer: waits for a granted request on an enabled channel,
// optionally inserts one idle cycle, then runs one bus cycle and returns to
// waiting. Produces the strobe, acknowledge and end-of-transfer outputs.
// Assumes enable drops in the same edge as the final bus cycle completes.
module sadma_seq
    import sadma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic idle_en,
    input  logic ack_en,
    input  logic end_en,
    input  logic last,
    input  logic dreq,
    input  logic bus_gnt,
    output logic in_cyc,
    output logic in_gap,
    output logic dack_n,
    output logic xfer_end
);

    seq_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_WAIT: if (enable && dreq && bus_gnt)
                         state_d = idle_en ? ST_GAP : ST_XFER;
            ST_GAP:  state_d = enable ? ST_XFER : ST_WAIT;
            ST_XFER: state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_WAIT;
        else
            state_q <= state_d;
    end

    assign in_cyc   = (state_q == ST_XFER);
    assign in_gap   = (state_q == ST_GAP);
    assign dack_n   = !(in_cyc && ack_en);
    assign xfer_end = end_en && last && (in_cyc || in_gap);

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_cyc |=> !in_cyc); // R4
    AST_GAP_THEN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && enable) |=> in_cyc); // R9
    AST_START_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !(dreq && bus_gnt && enable)) |=> state_q == ST_WAIT); // R10

endmodule

// File: rtl/sadma_engine.sv
// Top of the single-address DMA channel. Connects the register file to the
// sequencer and drives the external bus master outputs. No data path: the
// peripheral and memory exchange data directly on the external bus.
// Assumes access size equals the bus width (BYTES).
module sadma_engine
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dreq,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic              bus_idle,
    output logic              dack_n,
    output logic              xfer_end,
    output logic              busy,
    output logic              done
);

    logic [ADDR_W-1:0] mem_addr;
    logic dir, ack_en, end_en, idle_en, last;

    sadma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTES(BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .xfer_done (bus_cyc),
        .mem_addr  (mem_addr),
        .enable    (busy),
        .dir       (dir),
        .ack_en    (ack_en),
        .end_en    (end_en),
        .idle_en   (idle_en),
        .last      (last),
        .done      (done)
    );

    sadma_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (busy),
        .idle_en  (idle_en),
        .ack_en   (ack_en),
        .end_en   (end_en),
        .last     (last),
        .dreq     (dreq),
        .bus_gnt  (bus_gnt),
        .in_cyc   (bus_cyc),
        .in_gap   (bus_idle),
        .dack_n   (dack_n),
        .xfer_end (xfer_end)
    );

    assign bus_addr = bus_cyc ? mem_addr : '0;
    assign bus_we   = bus_cyc && dir;

    AST_ACK_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        !dack_n |-> bus_cyc); // R4
    AST_END_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |-> (bus_cyc || bus_idle)); // R8
    AST_NO_CYC_IDLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> busy); // R10

endmodule

// File: tb/test_sadma_engine.sv
module test_sadma_engine;

    localparam int AW = 32;
    localparam int BY = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dreq = 1'b0;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_cyc, bus_we, bus_idle, dack_n, xfer_end, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    // captured per transfer
    logic [AW-1:0] c_addr;
    logic          c_we, c_ack_n, c_end, c_prev_idle, c_prev_end, c_found;

    sadma_engine #(.ADDR_W(AW), .CNT_W(16), .BYTES(BY)) i_sadma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_gnt(bus_gnt),
        .bus_addr(bus_addr), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_idle(bus_idle), .dack_n(dack_n), .xfer_end(xfer_end),
        .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [AW-1:0] ctl(input bit en, input bit dir, input bit ack,
                                          input bit fin, input bit [1:0] stp, input bit idl);
        return AW'({idl, stp, fin, ack, dir, en});
    endfunction

    // Wait for the next bus cycle, capture it and check it lasts one cycle (R4)
    task automatic next_cyc();
        c_found = 1'b0; c_prev_idle = 1'b0; c_prev_end = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_cyc) begin
                c_found = 1'b1; c_addr = bus_addr; c_we = bus_we;
                c_ack_n = dack_n; c_end = xfer_end;
                break;
            end
            c_prev_idle = bus_idle; c_prev_end = xfer_end;
        end
        check("R4 cycle seen", AW'(c_found), 1);
        @(negedge clk);
        check("R4 single cycle", AW'(bus_cyc), 0);
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_cyc || !dack_n) seen++;
        end
        check(req, AW'(seen), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", AW'(busy), 0);
        check("R1 done", AW'(done), 0);
        check("R1 bus_cyc", AW'(bus_cyc), 0);
        check("R1 bus_idle", AW'(bus_idle), 0);
        check("R1 xfer_end", AW'(xfer_end), 0);
        check("R1 dack_n", AW'(dack_n), 1);
    endtask

    task automatic t_read_inc();
        wr(2'd0, 32'h100); wr(2'd1, 32'h800); wr(2'd2, 3);
        wr(2'd3, ctl(1, 0, 1, 1, 2'b01, 0));
        dreq = 1'b1; bus_gnt = 1'b1;
        for (int k = 0; k < 3; k++) begin
            next_cyc();
            check("R2 R6 addr", c_addr, 32'h100 + AW'(k * BY));
            check("R2 read", AW'(c_we), 0);
            check("R4 ack low", AW'(c_ack_n), 0);
            check("R8 end", AW'(c_end), AW'(k == 2));
        end
        check("R7 busy off", AW'(busy), 0);
        check("R7 done", AW'(done), 1);
        quiet(6, "R7 no more cycles");
        dreq = 1'b0;
    endtask

    task automatic t_write_dec();
        wr(2'd1, 32'h40); wr(2'd0, 32'h900); wr(2'd2, 2);
        wr(2'd3, ctl(1, 1, 0, 0, 2'b10, 0));
        dreq = 1'b1; bus_gnt = 1'b1;
        for (int k = 0; k < 2; k++) begin
            next_cyc();
            check("R3 R6 addr", c_addr, 32'h40 - AW'(k * BY));
            check("R3 write", AW'(c_we), 1);
            check("R5 ack high", AW'(c_ack_n), 1);
            check("R8 end off", AW'(c_end), 0);
        end
        dreq = 1'b0;
        check("R7 done", AW'(done), 1);
    endtask

    task automatic t_idle_fixed();
        wr(2'd0, 32'h200); wr(2'd2, 2);
        wr(2'd3, ctl(1, 0, 1, 1, 2'b11, 1));
        dreq = 1'b1; bus_gnt = 1'b1;
        for (int k = 0; k < 2; k++) begin
            next_cyc();
            check("R6 hold addr", c_addr, 32'h200);
            check("R9 idle before", AW'(c_prev_idle), 1);
            check("R9 end in idle", AW'(c_prev_end), AW'(k == 1));
            check("R8 end in cycle", AW'(c_end), AW'(k == 1));
        end
        dreq = 1'b0;
    endtask

    task automatic t_ignore();
        wr(2'd0, 32'h300); wr(2'd2, 2);
        wr(2'd3, ctl(0, 0, 1, 0, 2'b00, 0));
        dreq = 1'b1; bus_gnt = 1'b1;
        quiet(6, "R10 disabled");
        bus_gnt = 1'b0;
        wr(2'd3, ctl(1, 0, 1, 0, 2'b00, 0));
        quiet(6, "R10 no grant");
        check("R10 still busy", AW'(busy), 1);
        bus_gnt = 1'b1;
        for (int k = 0; k < 2; k++) begin
            next_cyc();
            check("R6 mode 00 hold", c_addr, 32'h300);
        end
        dreq = 1'b0;
    endtask

    task automatic t_sticky();
        check("R11 done set", AW'(done), 1);
        wr(2'd2, 0);
        check("R11 done kept", AW'(done), 1);
        wr(2'd3, ctl(1, 0, 1, 0, 2'b00, 0));
        check("R11 done cleared", AW'(done), 0);
        check("R11 zero count idle", AW'(busy), 0);
        dreq = 1'b1; bus_gnt = 1'b1;
        quiet(5, "R11 no cycles");
        dreq = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_inc();
        t_write_dec();
        t_idle_fixed();
        t_ignore();
        t_sticky();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule